// File: doc/BRIEF.md
# Byte-Wide Single-Cycle Processor Core

This block is a small processor that executes one 8-bit instruction per clock. It reads its instruction from an external instruction memory addressed by its own program counter. The memory port is combinational: the word presented on `imemData` must belong to the address on `imemAddr` in the same cycle. The core has six 8-bit general registers, R0 to R5. Register slot 6 is shared by an input port, which copies can read, and an output port, which copies can write. The registers have fixed roles. Immediates land in R0. Arithmetic and logic always combine R1 with R2 into R3. Jumps always go to the address held in R0 and decide on the value in R3.

The two top bits of every instruction pick one of four classes: small-constant load, calculate, copy, or conditional jump. All architectural state changes at the one clock edge that ends the instruction. A write to the output port is marked by a one-cycle valid pulse, which lets a consumer capture each produced value exactly once.

Top module: `byte_core`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, clears the program counter, R0 to R5, the output port value and the output valid strobe to zero.
- R2: When no jump is taken, the program counter advances by one each cycle and wraps from 255 to 0.
- R3: Bits [7:6] select the class: 00 constant load, 01 calculate, 10 copy, 11 condition. A constant load writes bits [5:0], zero-extended, into R0.
- R4: In the calculate class, bits [2:0] select the logic operation written to R3: 000 R1 OR R2, 001 NAND, 010 NOR, 011 AND.
- R5: In the calculate class, code 100 writes R1+R2 modulo 256 to R3 and code 101 writes R1-R2 in two's complement to R3.
- R6: Calculate codes 110 and 111 leave all registers and the output port unchanged; only the program counter advances.
- R7: In the copy class, the source is bits [5:3] and the destination is bits [2:0]. Source codes 0 to 5 read R0 to R5, 6 reads the input port and 7 reads zero. Destination codes 0 to 5 write R0 to R5.
- R8: A copy to destination code 6 places the source value on the output port, and `outValid` is high for exactly the following cycle. Destination code 7 changes nothing and raises no strobe.
- R9: In the condition class, bits [2:0] select the test on R3 read as a signed byte: 000 never, 001 =0, 010 <0, 011 <=0, 100 always, 101 !=0, 110 >=0, 111 >0. A passing test loads the program counter with R0; otherwise R2 applies.
- R10: The output port keeps its last written value until the next copy to destination code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 8 | Instruction memory address (program counter) |
| imemData | input | 8 | Instruction word at `imemAddr`, same cycle |
| inPort | input | 8 | Input port value, read by copies with source code 6 |
| outPort | output | 8 | Output port value, written by copies with destination code 6 |
| outValid | output | 1 | High for one cycle after each output port write |

## Verification
Register contents never reach a port directly. A corrupted register stays hidden until a copy to the output port exposes it, or until it steers a jump. The bench therefore follows every calculation with a copy to the output and compares the result one cycle after that copy. It also compares the address bus against an independent model in every cycle, so a wrong program counter, or a jump decided from a wrong R3 or R0, shows up in the very next cycle. A stuck or spurious strobe shows on `outValid` in the cycle after the offending instruction.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

  localparam int INSN_W   = 8;
  localparam int IMM_W    = 6;
  localparam int SEL_W    = 3;
  localparam int NUM_GP   = 6;
  localparam int IMM_DST  = 0;
  localparam int ALU_DST  = 3;
  localparam int JMP_SRC  = 0;

  localparam logic [SEL_W-1:0] SEL_PORT = 3'd6;
  localparam logic [SEL_W-1:0] SEL_ZERO = 3'd7;

  localparam logic [SEL_W-1:0] ALU_OR   = 3'd0;
  localparam logic [SEL_W-1:0] ALU_NAND = 3'd1;
  localparam logic [SEL_W-1:0] ALU_NOR  = 3'd2;
  localparam logic [SEL_W-1:0] ALU_AND  = 3'd3;
  localparam logic [SEL_W-1:0] ALU_ADD  = 3'd4;
  localparam logic [SEL_W-1:0] ALU_SUB  = 3'd5;

  typedef enum logic [1:0] {
    CLS_IMM  = 2'b00,
    CLS_CALC = 2'b01,
    CLS_COPY = 2'b10,
    CLS_COND = 2'b11
  } insnClass_e;

  typedef struct packed {
    logic             immWe;
    logic [IMM_W-1:0] immVal;
    logic             aluWe;
    logic [SEL_W-1:0] aluOp;
    logic             regWe;
    logic [SEL_W-1:0] srcSel;
    logic [SEL_W-1:0] dstSel;
    logic             outWe;
    logic             jumpTake;
  } coreCtrl_t;

endpackage

// File: rtl/byte_core_ctrl.sv
module byte_core_ctrl
  import byte_core_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              r3Zero,
  input  logic              r3Neg,
  output coreCtrl_t         ctrl
);

  insnClass_e insnClass;
  logic [SEL_W-1:0] lowField;
  logic [SEL_W-1:0] midField;
  logic condPass;

  assign insnClass = insnClass_e'(insn[7:6]);
  assign lowField  = insn[2:0];
  assign midField  = insn[5:3];

  always_comb begin
    unique case (lowField)
      3'd0:    condPass = 1'b0;
      3'd1:    condPass = r3Zero;
      3'd2:    condPass = r3Neg;
      3'd3:    condPass = r3Neg | r3Zero;
      3'd4:    condPass = 1'b1;
      3'd5:    condPass = ~r3Zero;
      3'd6:    condPass = ~r3Neg;
      default: condPass = ~r3Neg & ~r3Zero;
    endcase
  end

  always_comb begin
    ctrl        = '0;
    ctrl.immVal = insn[IMM_W-1:0];
    ctrl.aluOp  = lowField;
    ctrl.srcSel = midField;
    ctrl.dstSel = lowField;
    unique case (insnClass)
      CLS_IMM:  ctrl.immWe    = 1'b1;
      CLS_CALC: ctrl.aluWe    = (lowField <= ALU_SUB);
      CLS_COPY: begin
        ctrl.regWe = (lowField < SEL_PORT);
        ctrl.outWe = (lowField == SEL_PORT);
      end
      default:  ctrl.jumpTake = condPass;
    endcase
  end

endmodule

// File: rtl/byte_core_dp.sv
module byte_core_dp
  import byte_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  coreCtrl_t         ctrl,
  input  logic [DATA_W-1:0] inPort,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] outPort,
  output logic              outValid,
  output logic              r3Zero,
  output logic              r3Neg
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] gpr     [NUM_GP];
  logic [DATA_W-1:0] gprNext [NUM_GP];
  logic [NUM_GP-1:0] gprWe;
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] aluRes;
  logic [DATA_W-1:0] immExt;

  assign immExt = {{PAD_W{1'b0}}, ctrl.immVal};

  always_comb begin
    srcVal = '0;
    if (ctrl.srcSel == SEL_PORT) begin
      srcVal = inPort;
    end else if (ctrl.srcSel != SEL_ZERO) begin
      for (int s = 0; s < NUM_GP; s++) begin
        if (ctrl.srcSel == SEL_W'(s)) srcVal = gpr[s];
      end
    end
  end

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_OR:   aluRes = gpr[1] | gpr[2];
      ALU_NAND: aluRes = ~(gpr[1] & gpr[2]);
      ALU_NOR:  aluRes = ~(gpr[1] | gpr[2]);
      ALU_AND:  aluRes = gpr[1] & gpr[2];
      ALU_ADD:  aluRes = gpr[1] + gpr[2];
      ALU_SUB:  aluRes = gpr[1] - gpr[2];
      default:  aluRes = gpr[ALU_DST];
    endcase
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : gen_gpr
    always_comb begin
      gprWe[g]   = ctrl.regWe && (ctrl.dstSel == SEL_W'(g));
      gprNext[g] = srcVal;
      if (g == IMM_DST && ctrl.immWe) begin
        gprWe[g]   = 1'b1;
        gprNext[g] = immExt;
      end
      if (g == ALU_DST && ctrl.aluWe) begin
        gprWe[g]   = 1'b1;
        gprNext[g] = aluRes;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)           gpr[g] <= '0;
      else if (gprWe[g]) gpr[g] <= gprNext[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                pc <= '0;
    else if (ctrl.jumpTake) pc <= gpr[JMP_SRC];
    else                    pc <= pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outPort  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctrl.outWe;
      if (ctrl.outWe) outPort <= srcVal;
    end
  end

  assign r3Zero = (gpr[ALU_DST] == '0);
  assign r3Neg  = gpr[ALU_DST][DATA_W-1];

endmodule

// File: rtl/byte_core.sv
module byte_core
  import byte_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imemAddr,
  input  logic [INSN_W-1:0] imemData,
  input  logic [DATA_W-1:0] inPort,
  output logic [DATA_W-1:0] outPort,
  output logic              outValid
);

  coreCtrl_t ctrl;
  logic r3Zero;
  logic r3Neg;

  byte_core_ctrl u_ctrl (
    .insn   (imemData),
    .r3Zero (r3Zero),
    .r3Neg  (r3Neg),
    .ctrl   (ctrl)
  );

  byte_core_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .inPort   (inPort),
    .pc       (imemAddr),
    .outPort  (outPort),
    .outValid (outValid),
    .r3Zero   (r3Zero),
    .r3Neg    (r3Neg)
  );

endmodule

// File: rtl/byte_core_chk.sv
module byte_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] imemAddr,
  input logic [7:0]        imemData,
  input logic [DATA_W-1:0] inPort,
  input logic [DATA_W-1:0] outPort,
  input logic              outValid
);

  logic isCond;
  logic toOut;
  assign isCond = (imemData[7:6] == 2'b11);
  assign toOut  = (imemData[7:6] == 2'b10) && (imemData[2:0] == 3'd6);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imemAddr == '0) && (outPort == '0) && !outValid);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !isCond |=> imemAddr == DATA_W'($past(imemAddr) + 1'b1));

  assert_never_jump_R9: assert property (@(posedge clk) disable iff (rst)
    (imemData == 8'hC0) |=> imemAddr == DATA_W'($past(imemAddr) + 1'b1));

  assert_input_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (imemData == 8'hB6) |=> outPort == $past(inPort));

  assert_out_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    toOut |=> outValid);

  assert_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !toOut |=> !outValid);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> $stable(outPort));

endmodule

bind byte_core byte_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .imemAddr (imemAddr),
  .imemData (imemData),
  .inPort   (inPort),
  .outPort  (outPort),
  .outValid (outValid)
);

// File: tb/byte_core_tb.sv
`timescale 1ns/1ps
module byte_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] imemAddr;
  logic [7:0] imemData;
  logic [7:0] inPort = 8'h00;
  logic [7:0] outPort;
  logic       outValid;

  logic [7:0] mem    [256];
  logic [7:0] stimIn [256];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] mR [6];
  logic [7:0] mPc;
  logic [7:0] mOut;
  logic       mValid;

  // {a, b, op, expected R3}; ops 6 and 7 keep the previous R3 (R6)
  localparam logic [26:0] VEC [9] = '{
    {8'hF0, 8'h3C, 3'd0, 8'hFC},
    {8'hF0, 8'h3C, 3'd1, 8'hCF},
    {8'hF0, 8'h3C, 3'd2, 8'h03},
    {8'hF0, 8'h3C, 3'd3, 8'h30},
    {8'hC8, 8'h64, 3'd4, 8'h2C},
    {8'h11, 8'h22, 3'd6, 8'h2C},
    {8'h33, 8'h44, 3'd7, 8'h2C},
    {8'h10, 8'h20, 3'd5, 8'hF0},
    {8'h05, 8'h05, 3'd5, 8'h00}
  };

  // program from address 36 on
  localparam logic [7:0] PROG [28] = '{
    8'h3F, 8'h86, 8'h2A, 8'h84, 8'hA5, 8'hAE, 8'hBD, 8'hAE,
    8'h87, 8'hB6, 8'hB3, 8'h34, 8'hC1, 8'hC2, 8'hB6, 8'hB6,
    8'h38, 8'hC6, 8'hC0, 8'hC5, 8'hB3, 8'h3D, 8'hC7, 8'hC3,
    8'hB6, 8'hB3, 8'h3F, 8'hC7
  };

  byte_core u_dut (
    .clk      (clk),
    .rst      (rst),
    .imemAddr (imemAddr),
    .imemData (imemData),
    .inPort   (inPort),
    .outPort  (outPort),
    .outValid (outValid)
  );

  assign imemData = mem[imemAddr];

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 6; i++) mR[i] = 8'h00;
    mPc = 8'h00; mOut = 8'h00; mValid = 1'b0;
  endtask

  task automatic modelStep();
    logic [7:0] ins;
    logic [7:0] src;
    logic [7:0] nxt;
    logic signed [7:0] sR3;
    bit take;
    ins = mem[mPc];
    nxt = mPc + 8'd1;
    mValid = 1'b0;
    sR3 = mR[3];
    case (ins[7:6])
      2'b00: mR[0] = {2'b00, ins[5:0]};
      2'b01: case (ins[2:0])
        3'd0: mR[3] = mR[1] | mR[2];
        3'd1: mR[3] = ~(mR[1] & mR[2]);
        3'd2: mR[3] = ~(mR[1] | mR[2]);
        3'd3: mR[3] = mR[1] & mR[2];
        3'd4: mR[3] = mR[1] + mR[2];
        3'd5: mR[3] = mR[1] - mR[2];
        default: ;
      endcase
      2'b10: begin
        if (ins[5:3] < 3'd6)       src = mR[ins[5:3]];
        else if (ins[5:3] == 3'd6) src = inPort;
        else                       src = 8'h00;
        if (ins[2:0] < 3'd6) mR[ins[2:0]] = src;
        else if (ins[2:0] == 3'd6) begin mOut = src; mValid = 1'b1; end
      end
      default: begin
        case (ins[2:0])
          3'd0: take = 0;
          3'd1: take = (sR3 == 0);
          3'd2: take = (sR3 < 0);
          3'd3: take = (sR3 <= 0);
          3'd4: take = 1;
          3'd5: take = (sR3 != 0);
          3'd6: take = (sR3 >= 0);
          default: take = (sR3 > 0);
        endcase
        if (take) nxt = mR[0];
      end
    endcase
    mPc = nxt;
  endtask

  task automatic runCycles(input int n);
    for (int k = 0; k < n; k++) begin
      inPort = stimIn[mPc];
      modelStep();
      @(negedge clk);
      check(imemAddr == mPc, "R2 R9 pc vs model", imemAddr, mPc);
      check(outPort == mOut, "R7 R8 R10 outPort vs model", outPort, mOut);
      check(outValid == mValid, "R8 outValid vs model", {7'd0, outValid}, {7'd0, mValid});
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; stimIn[i] = 8'h00; end
    for (int i = 0; i < 9; i++) begin
      mem[4*i]       = 8'hB1;
      mem[4*i+1]     = 8'hB2;
      mem[4*i+2]     = {5'b01000, VEC[i][10:8]};
      mem[4*i+3]     = 8'h9E;
      stimIn[4*i]    = VEC[i][26:19];
      stimIn[4*i+1]  = VEC[i][18:11];
    end
    for (int i = 0; i < 28; i++) mem[36+i] = PROG[i];
    stimIn[45] = 8'h5A;
    stimIn[46] = 8'h80;
    stimIn[56] = 8'h00;
    stimIn[61] = 8'h01;

    doReset();
    // R1 reset state at the ports
    check(imemAddr == 8'h00, "R1 pc after reset", imemAddr, 8'h00);
    check(outPort == 8'h00, "R1 outPort after reset", outPort, 8'h00);
    check(outValid == 1'b0, "R1 outValid after reset", {7'd0, outValid}, 8'h00);

    // vector table: R4 logic, R5 add/sub, R6 unused codes
    for (int v = 0; v < 9; v++) begin
      runCycles(4);
      check(outValid == 1'b1, "R8 strobe after vector copy", {7'd0, outValid}, 8'h01);
      check(outPort == VEC[v][7:0], "R4 R5 R6 calc result", outPort, VEC[v][7:0]);
    end

    runCycles(2);
    check(outPort == 8'h3F, "R3 constant 63 into R0", outPort, 8'h3F);
    runCycles(4);
    check(outPort == 8'h2A, "R7 chained register copies", outPort, 8'h2A);
    runCycles(2);
    check(outPort == 8'h00, "R7 source code 7 clears", outPort, 8'h00);
    runCycles(1);
    check(outValid == 1'b0 && outPort == 8'h00, "R8 destination 7 ignored", outPort, 8'h00);
    runCycles(1);
    check(outPort == 8'h5A, "R7 input port source", outPort, 8'h5A);
    runCycles(3);
    check(imemAddr == 8'd49, "R9 eq0 not taken on negative", imemAddr, 8'd49);
    runCycles(1);
    check(imemAddr == 8'd52, "R9 lt0 taken", imemAddr, 8'd52);
    runCycles(4);
    check(imemAddr == 8'd56, "R9 gteq0 never neq0", imemAddr, 8'd56);
    runCycles(4);
    check(imemAddr == 8'd61, "R9 gt0 not taken le0 taken on zero", imemAddr, 8'd61);
    runCycles(3);
    check(imemAddr == 8'd63, "R9 gt0 taken on positive", imemAddr, 8'd63);
    runCycles(3);
    check(imemAddr == 8'd63, "R9 self loop", imemAddr, 8'd63);
    check(outPort == 8'h5A && !outValid, "R10 output holds", outPort, 8'h5A);

    // mid-run reset, then new program
    doReset();
    check(imemAddr == 8'h00 && outPort == 8'h00 && !outValid, "R1 second reset", outPort, 8'h00);
    mem[0] = 8'h9E; mem[1] = 8'h8E; mem[2] = 8'hA6; mem[3] = 8'hAE;
    for (int i = 4; i < 256; i++) begin mem[i] = 8'h47; stimIn[i] = 8'h00; end
    for (int i = 0; i < 4; i++) stimIn[i] = 8'h00;
    for (int r = 0; r < 4; r++) begin
      runCycles(1);
      check(outValid && outPort == 8'h00, "R1 registers cleared", outPort, 8'h00);
    end
    runCycles(252);
    check(imemAddr == 8'h00, "R2 pc wraps to 0", imemAddr, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule